// File: doc/BRIEF.md
# Flattened Butterfly Route Computation

This block is the route-computation stage of a single router in a flattened butterfly network. Every node address is a fixed number of base-K digits, one per dimension. Along any one dimension, the routers that agree in all other digits are fully connected. A hop in dimension d therefore rewrites digit d to any other value. For each head flit the block receives the local router address, the destination, the header's phase bit and intermediate address, a flag saying the packet is being injected here, and the occupancy of every network output queue. It returns the output port and the rewritten phase and intermediate fields.

Three policies are selectable per router. Minimal adaptive picks the least occupied among the ports that correct one differing digit. Randomized non-minimal draws an intermediate node at injection and routes minimally to it, then minimally to the destination. Global adaptive compares the hop-weighted congestion of the minimal path against a random non-minimal path at injection, and keeps the minimal path unless the detour is strictly cheaper.

Decisions are registered behind a valid/ready handshake. The block accepts one head flit per cycle.

Top module: `fbr_route`

## Requirements
- R1: Digit d of an address occupies bits [d*DW +: DW]. A hop in dimension d from current digit c to target digit t leaves on port d*(K-1) + (t<c ? t : t-1). The ejection port is DIMS*(K-1), and no other value appears on out_port.
- R2: When the block routes minimally, the candidates are only the dimensions where the current and target digits differ. The port whose queue occupancy is smallest wins, and equal occupancies go to the lowest dimension.
- R3: A packet whose destination equals the current address, and which is not still heading to an intermediate node, goes to the ejection port with the phase bit cleared.
- R4: In mode 1 (randomized), an injected packet (in_new=1) takes a pseudo-random intermediate address. It leaves with phase 1 and routes one digit toward that address. If the draw equals the current address, it leaves with phase 0 and routes minimally to the destination.
- R5: A packet with phase 1 routes minimally toward in_mid. When the current address equals in_mid, the phase bit clears and the packet routes to the destination in that same decision.
- R6: In mode 2 (global adaptive), an injected packet compares two products. The minimal product is (hops to destination) times (smallest minimal occupancy). The non-minimal product is (hops via the random node) times (smallest occupancy toward that node). The block goes non-minimal only when the non-minimal product is strictly smaller, so equal queues always give the minimal route.
- R7: Mode 0 (minimal adaptive) never sets the phase bit on an injected packet, even when the minimal queues are full.
- R8: in_ready is high whenever the output register is empty or out_ready is high. While out_valid is high and out_ready is low, out_port, out_phase and out_mid hold, and a newly presented packet is not taken.
- R9: After reset, out_valid is low and in_ready is high.
- R10: With out_ready held high, packets presented on consecutive cycles each produce their decision one cycle after acceptance, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 minimal adaptive, 1 randomized, 2 global adaptive (3 acts as 0) |
| in_valid | input | 1 | Head flit present |
| in_ready | output | 1 | Block can take a head flit |
| in_new | input | 1 | Packet is being injected at this router |
| in_phase | input | 1 | Header: still heading to intermediate node |
| cur_addr | input | AW | Address of this router |
| dst_addr | input | AW | Header destination |
| in_mid | input | AW | Header intermediate address |
| q_occ | input | NQ*QW | Occupancy of each network output port, port p at [p*QW +: QW] |
| out_valid | output | 1 | Route decision present |
| out_ready | input | 1 | Downstream takes the decision |
| out_port | output | PW | Selected output port |
| out_phase | output | 1 | Updated phase bit |
| out_mid | output | AW | Updated intermediate address |

## Verification
The embedded properties watch several behaviours on every cycle:
- the chosen candidate never has more occupancy than any other differing dimension;
- a port code never exceeds the ejection code;
- a stalled decision never changes, and the register empty implies ready;
- a local, settled packet always lands on ejection;
- the pseudo-random source never locks up.

The directed scenarios cover behaviour that only stimulus can show: exact port numbers for specific digit pairs, tie-breaking, phase clearing on arrival, and minimal routes on benign queues versus detours under congestion. Because the random draw is not visible, randomized results are checked for consistency with the reported intermediate address.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic [1:0] {
    RM_MIN    = 2'd0,
    RM_RAND   = 2'd1,
    RM_GLOBAL = 2'd2,
    RM_RSVD   = 2'd3
  } route_mode_e;
endpackage

// File: rtl/fbr_lfsr.sv
module fbr_lfsr #(
  parameter int K    = 4,
  parameter int DIMS = 2,
  parameter int LW   = 16,
  parameter logic [15:0] TAPS = 16'hB400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [DIMS*((K>2)?$clog2(K):1)-1:0] rnd_addr
);
  localparam int DW = (K > 2) ? $clog2(K) : 1;

  logic [LW-1:0] state_q, state_d;

  always_comb begin
    if (state_q[0]) state_d = (state_q >> 1) ^ TAPS[LW-1:0];
    else            state_d = state_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= {{(LW-1){1'b0}}, 1'b1};
    else        state_q <= state_d;
  end

  for (genvar d = 0; d < DIMS; d++) begin : g_dig
    logic [DW-1:0] raw;
    assign raw = state_q[d*DW +: DW];
    assign rnd_addr[d*DW +: DW] = (int'(raw) >= K) ? DW'(int'(raw) - K) : raw;
  end

  // R4
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0);
endmodule

// File: rtl/fbr_min_select.sv
module fbr_min_select #(
  parameter int K    = 4,
  parameter int DIMS = 2,
  parameter int QW   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [DIMS*((K>2)?$clog2(K):1)-1:0] cur,
  input  logic [DIMS*((K>2)?$clog2(K):1)-1:0] tgt,
  input  logic [DIMS*(K-1)*QW-1:0]          q_occ,
  output logic [$clog2(DIMS*(K-1)+1)-1:0]   best_port,
  output logic [QW-1:0]                     best_occ,
  output logic [$clog2(DIMS+1)-1:0]         hops,
  output logic                              any
);
  localparam int DW = (K > 2) ? $clog2(K) : 1;
  localparam int NQ = DIMS * (K - 1);
  localparam int PW = $clog2(NQ + 1);
  localparam int HW = $clog2(DIMS + 1);

  logic [DIMS-1:0]         cand_diff;
  logic [DIMS-1:0][PW-1:0] cand_port;
  logic [DIMS-1:0][QW-1:0] cand_occ;

  for (genvar d = 0; d < DIMS; d++) begin : g_cand
    logic [DW-1:0] c_dig, t_dig, off;
    assign c_dig = cur[d*DW +: DW];
    assign t_dig = tgt[d*DW +: DW];
    assign off   = (t_dig < c_dig) ? t_dig : DW'(t_dig - 1'b1);
    assign cand_diff[d] = (c_dig != t_dig);
    assign cand_port[d] = PW'(d * (K - 1)) + PW'(off);
    assign cand_occ[d]  = cand_diff[d] ? q_occ[int'(cand_port[d])*QW +: QW] : '0;

    // R2
    cand_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_diff[d] |-> (any && (best_occ <= cand_occ[d])));
  end

  always_comb begin
    best_port = PW'(NQ);
    best_occ  = '0;
    hops      = '0;
    any       = 1'b0;
    for (int d = 0; d < DIMS; d++) begin
      if (cand_diff[d]) begin
        hops = hops + HW'(1);
        if (!any || (cand_occ[d] < best_occ)) begin
          best_port = cand_port[d];
          best_occ  = cand_occ[d];
        end
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fbr_out_reg.sv
module fbr_out_reg #(
  parameter int PW = 3,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] d_port,
  input  logic          d_phase,
  input  logic [AW-1:0] d_mid,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] q_port,
  output logic          q_phase,
  output logic [AW-1:0] q_mid
);
  logic          vld_d;
  logic          load_en;
  logic [PW-1:0] port_d;
  logic          phase_d;
  logic [AW-1:0] mid_d;

  assign in_ready = !out_valid || out_ready;
  assign load_en  = in_valid && in_ready;

  always_comb begin
    vld_d   = out_valid;
    port_d  = q_port;
    phase_d = q_phase;
    mid_d   = q_mid;
    if (in_ready) vld_d = in_valid;
    if (load_en) begin
      port_d  = d_port;
      phase_d = d_phase;
      mid_d   = d_mid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_port    <= '0;
      q_phase   <= 1'b0;
      q_mid     <= '0;
    end else begin
      out_valid <= vld_d;
      q_port    <= port_d;
      q_phase   <= phase_d;
      q_mid     <= mid_d;
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_port) && $stable(q_phase) && $stable(q_mid)));
  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: rtl/fbr_route.sv
module fbr_route
  import fbr_pkg::*;
#(
  parameter int K    = 4,
  parameter int DIMS = 2,
  parameter int QW   = 4,
  localparam int DW  = (K > 2) ? $clog2(K) : 1,
  localparam int AW  = DIMS * DW,
  localparam int NQ  = DIMS * (K - 1),
  localparam int PW  = $clog2(NQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_new,
  input  logic             in_phase,
  input  logic [AW-1:0]    cur_addr,
  input  logic [AW-1:0]    dst_addr,
  input  logic [AW-1:0]    in_mid,
  input  logic [NQ*QW-1:0] q_occ,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PW-1:0]    out_port,
  output logic             out_phase,
  output logic [AW-1:0]    out_mid
);
  localparam int HW  = $clog2(DIMS + 1);
  localparam int HW2 = $clog2(2 * DIMS + 1);
  localparam int PRW = HW2 + QW;
  localparam logic [PW-1:0] EJECT = PW'(NQ);

  route_mode_e   rmode;
  logic [AW-1:0] rnd_addr;
  logic [AW-1:0] mid_src;

  logic [PW-1:0] dst_port, mid_port;
  logic [QW-1:0] dst_occ, mid_occ;
  logic [HW-1:0] dst_hops, mid_hops, rnd_dst_hops;
  logic          dst_any, mid_any;

  logic [PRW-1:0] min_prod, nonmin_prod;
  logic           phase_want, phase_eff;
  logic [PW-1:0]  sel_port;
  logic [AW-1:0]  sel_mid;

  assign rmode   = route_mode_e'(mode);
  assign mid_src = in_new ? rnd_addr : in_mid;

  fbr_lfsr #(.K(K), .DIMS(DIMS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd_addr(rnd_addr)
  );

  fbr_min_select #(.K(K), .DIMS(DIMS), .QW(QW)) u_sel_dst (
    .clk(clk), .rst_n(rst_n), .cur(cur_addr), .tgt(dst_addr), .q_occ(q_occ),
    .best_port(dst_port), .best_occ(dst_occ), .hops(dst_hops), .any(dst_any)
  );

  fbr_min_select #(.K(K), .DIMS(DIMS), .QW(QW)) u_sel_mid (
    .clk(clk), .rst_n(rst_n), .cur(cur_addr), .tgt(mid_src), .q_occ(q_occ),
    .best_port(mid_port), .best_occ(mid_occ), .hops(mid_hops), .any(mid_any)
  );

  // hops from the random node onward to the destination
  always_comb begin
    rnd_dst_hops = '0;
    for (int d = 0; d < DIMS; d++)
      if (rnd_addr[d*DW +: DW] != dst_addr[d*DW +: DW]) rnd_dst_hops = rnd_dst_hops + HW'(1);
  end

  assign min_prod    = PRW'(dst_hops) * PRW'(dst_occ);
  assign nonmin_prod = (PRW'(mid_hops) + PRW'(rnd_dst_hops)) * PRW'(mid_occ);

  always_comb begin
    phase_want = in_phase;
    if (in_new) begin
      unique case (rmode)
        RM_RAND:   phase_want = 1'b1;
        RM_GLOBAL: phase_want = nonmin_prod < min_prod;
        default:   phase_want = 1'b0;
      endcase
    end
    phase_eff = phase_want && mid_any;
    if (phase_eff)     sel_port = mid_port;
    else if (dst_any)  sel_port = dst_port;
    else               sel_port = EJECT;
    sel_mid = phase_eff ? mid_src : in_mid;
  end

  fbr_out_reg #(.PW(PW), .AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .d_port(sel_port), .d_phase(phase_eff), .d_mid(sel_mid),
    .out_valid(out_valid), .out_ready(out_ready),
    .q_port(out_port), .q_phase(out_phase), .q_mid(out_mid)
  );

  // R1
  port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_port <= EJECT));
  // R3
  local_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_new && (cur_addr == dst_addr) && (!in_phase || in_mid == cur_addr))
    |=> (out_valid && out_port == EJECT && !out_phase));
  // R7
  min_no_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_new && mode == 2'd0) |=> !out_phase);
endmodule

// File: tb/fbr_route_test.sv
module fbr_route_test;
  localparam int K = 4, DIMS = 2, QW = 4;
  localparam int AW = 4, NQ = 6, PW = 3, EJ = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          in_valid, in_ready, in_new, in_phase;
  logic [AW-1:0] cur_addr, dst_addr, in_mid;
  logic [NQ*QW-1:0] q_occ;
  logic          out_valid, out_ready, out_phase;
  logic [PW-1:0] out_port;
  logic [AW-1:0] out_mid;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  fbr_route #(.K(K), .DIMS(DIMS), .QW(QW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_new(in_new), .in_phase(in_phase), .cur_addr(cur_addr), .dst_addr(dst_addr),
    .in_mid(in_mid), .q_occ(q_occ), .out_valid(out_valid), .out_ready(out_ready),
    .out_port(out_port), .out_phase(out_phase), .out_mid(out_mid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dig(input logic [AW-1:0] a, input int d);
    return int'((a >> (2 * d)) & 4'h3);
  endfunction

  function automatic int enc(input int d, input int c, input int t);
    return d * (K - 1) + ((t < c) ? t : t - 1);
  endfunction

  function automatic int port_target(input int p, input int c);
    int off = p % (K - 1);
    return (off < c) ? off : off + 1;
  endfunction

  task automatic set_q(input int p, input int v);
    q_occ[p*QW +: QW] = QW'(v);
  endtask

  // present one packet, sample the registered decision one cycle later
  task automatic send(input logic [1:0] m, input logic nw, input logic ph,
                      input logic [AW-1:0] cur, input logic [AW-1:0] dst, input logic [AW-1:0] mid);
    @(negedge clk);
    mode = m; in_new = nw; in_phase = ph; cur_addr = cur; dst_addr = dst; in_mid = mid;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_minimal();
    q_occ = '0;
    // cur digits (0,0), dst digits d0=2, d1=3 -> ports 1 and 5
    set_q(1, 5); set_q(5, 2);
    send(2'd0, 1'b0, 1'b0, 4'h0, 4'hE, 4'h0);
    chk(out_valid && out_port == 3'd5, "R2 smaller queue", int'(out_port), 5);
    set_q(1, 2); set_q(5, 2);
    send(2'd0, 1'b0, 1'b0, 4'h0, 4'hE, 4'h0);
    chk(out_port == 3'd1, "R2 tie lowest dim", int'(out_port), 1);
    set_q(1, 3); set_q(5, 7);
    send(2'd0, 1'b0, 1'b0, 4'h0, 4'hE, 4'h0);
    chk(out_port == 3'd1, "R2 dim0 lighter", int'(out_port), 1);
    chk(out_phase == 1'b0, "R2 phase stays clear", int'(out_phase), 0);
  endtask

  task automatic t_encoding();
    q_occ = '0;
    // cur (3,2) -> dst (0,2): dim0, t=0<c=3 -> port 0
    send(2'd0, 1'b0, 1'b0, 4'b1011, 4'b1000, 4'h0);
    chk(out_port == 3'(enc(0, 3, 0)), "R1 lower digit", int'(out_port), enc(0, 3, 0));
    // cur (1,0) -> dst (1,3): dim1, t=3>c=0 -> port 5
    send(2'd0, 1'b0, 1'b0, 4'b0001, 4'b1101, 4'h0);
    chk(out_port == 3'(enc(1, 0, 3)), "R1 upper digit", int'(out_port), enc(1, 0, 3));
  endtask

  task automatic t_eject();
    q_occ = '0;
    send(2'd0, 1'b0, 1'b0, 4'h5, 4'h5, 4'h0);
    chk(out_port == 3'(EJ), "R3 eject", int'(out_port), EJ);
    send(2'd1, 1'b0, 1'b1, 4'h5, 4'h5, 4'h5);
    chk(out_port == 3'(EJ) && !out_phase, "R3 eject after arrival", int'(out_port), EJ);
  endtask

  task automatic t_phase();
    q_occ = '0;
    // heading to mid (0,1): dim1 digit 0->1 -> port 3
    send(2'd0, 1'b0, 1'b1, 4'h0, 4'hF, 4'b0100);
    chk(out_port == 3'd3, "R5 toward mid", int'(out_port), 3);
    chk(out_phase && out_mid == 4'b0100, "R5 phase kept", int'(out_mid), 4);
    // arrived at mid, dst (2,1): dim0 0->2 -> port 1
    send(2'd1, 1'b0, 1'b1, 4'b0100, 4'b0110, 4'b0100);
    chk(out_port == 3'd1, "R5 continue to dst", int'(out_port), 1);
    chk(!out_phase, "R5 phase cleared", int'(out_phase), 0);
  endtask

  task automatic t_random();
    int detours = 0;
    q_occ = '0;
    for (int i = 0; i < 8; i++) begin
      repeat (i + 1) @(negedge clk);
      send(2'd1, 1'b1, 1'b0, 4'h0, 4'h5, 4'h0);
      if (out_phase) begin
        int p = int'(out_port);
        int d = p / (K - 1);
        detours++;
        chk(out_mid != 4'h0, "R4 mid differs from cur", int'(out_mid), 1);
        chk(p < EJ && port_target(p, 0) == dig(out_mid, d), "R4 hop toward mid",
            port_target(p, 0), dig(out_mid, d));
      end else begin
        chk(out_port == 3'd0, "R4 draw hit cur, minimal", int'(out_port), 0);
      end
    end
    chk(detours > 0, "R4 some detour", detours, 1);
  endtask

  task automatic t_global();
    int detours = 0;
    q_occ = '0;
    for (int i = 0; i < 4; i++) begin
      repeat (i + 1) @(negedge clk);
      send(2'd2, 1'b1, 1'b0, 4'h0, 4'h1, 4'h0);
      chk(!out_phase && out_port == 3'd0, "R6 benign minimal", int'(out_port), 0);
    end
    set_q(0, 15);
    for (int i = 0; i < 8; i++) begin
      repeat (i + 1) @(negedge clk);
      send(2'd2, 1'b1, 1'b0, 4'h0, 4'h1, 4'h0);
      if (out_phase) begin
        detours++;
        chk(out_port != 3'd0 && out_port < 3'(EJ), "R6 detour uses empty queue", int'(out_port), 1);
      end else begin
        chk(out_port == 3'd0, "R6 minimal kept", int'(out_port), 0);
      end
    end
    chk(detours > 0, "R6 congestion detour", detours, 1);
    send(2'd0, 1'b1, 1'b0, 4'h0, 4'h1, 4'h0);
    chk(!out_phase && out_port == 3'd0, "R7 minimal mode ignores congestion", int'(out_port), 0);
  endtask

  task automatic t_stall();
    q_occ = '0;
    @(negedge clk);
    mode = 2'd0; in_new = 1'b0; in_phase = 1'b0; in_mid = 4'h0;
    cur_addr = 4'h0; dst_addr = 4'h2; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    dst_addr = 4'b0100;
    chk(out_valid && out_port == 3'd1, "R8 first loaded", int'(out_port), 1);
    chk(in_ready == 1'b0, "R8 not ready while stalled", int'(in_ready), 0);
    repeat (2) begin
      @(negedge clk);
      chk(out_valid && out_port == 3'd1, "R8 held", int'(out_port), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_port == 3'd3, "R8 second after release", int'(out_port), 3);
    @(negedge clk);
    chk(!out_valid, "R8 drained", int'(out_valid), 0);
  endtask

  task automatic t_stream();
    q_occ = '0;
    @(negedge clk);
    mode = 2'd0; in_new = 1'b0; in_phase = 1'b0; in_mid = 4'h0; out_ready = 1'b1;
    cur_addr = 4'h0; dst_addr = 4'h1; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid && out_port == 3'd0, "R10 stream 0", int'(out_port), 0);
    dst_addr = 4'h3;
    @(negedge clk);
    chk(out_valid && out_port == 3'd2, "R10 stream 1", int'(out_port), 2);
    dst_addr = 4'b1000;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_port == 3'd4, "R10 stream 2", int'(out_port), 4);
  endtask

  initial begin
    rst_n = 1'b0; mode = '0; in_valid = 1'b0; in_new = 1'b0; in_phase = 1'b0;
    cur_addr = '0; dst_addr = '0; in_mid = '0; q_occ = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_minimal();
    t_encoding();
    t_eject();
    t_phase();
    t_random();
    t_global();
    t_stall();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule